// File: doc/BRIEF.md
# Serial Flash Read-Out Engine

This block is the target-side read path of a serial NOR flash. It watches the chip-select, serial clock and serial data-in pins, decodes a fixed set of read-type opcodes, and shifts data back out. The pins are oversampled by a faster system clock, so every serial clock edge is seen as a one-cycle event inside the block. Array reads come from a small internal byte memory with a parameterized address width. A write port loads the memory before a transfer starts.

Array reads can use one output pin or two. Three fixed identification sequences are also supported. The read pointer advances after each byte and wraps at the top of the memory, so one command can stream data with no gap for as long as chip-select stays low. Both output pins are returned as a value plus an enable. The block drives a pin only while it is actually sending data.

Top module: `spi_rd_engine`

## Requirements
- R1: Opcode, address and dummy bits are taken on rising `sck` edges, most significant bit first. Output bits change only after falling `sck` edges. Both clock-idle-low (mode 0) and clock-idle-high (mode 3) framing work.
- R2: Opcode 0x03, followed by 24 address bits, returns data bit 7 of the addressed byte after the falling edge that follows the last address bit. There are no dummy clocks.
- R3: Opcode 0x0B takes 24 address bits and then 8 dummy clocks before the first data bit. Data comes out on `so_o` only.
- R4: Opcode 0x3B has the same framing as 0x0B, but each byte takes 4 clocks. `so_o` carries bits 7,5,3,1 and `si_o` carries bits 6,4,2,0, in that order. `si_oe` rises only once data starts.
- R5: For array reads, only the low AW address bits are used. The pointer increments after every byte and wraps from 2^AW-1 to 0.
- R6: Opcode 0x9F returns 0x8C, 0x20, 0x13, and then 0x00 for every later byte.
- R7: Opcode 0x90 with a 24-bit address alternates 0x8C and 0x12. It starts with 0x12 when address bit 0 is 1, and with 0x8C otherwise.
- R8: Opcode 0xAB followed by 24 dummy clocks returns 0x12 repeatedly.
- R9: A high `ce_n` at any point aborts the instruction, drops both output enables, and leaves the engine ready for a fresh opcode.
- R10: Both output enables are low out of reset, while `ce_n` is high, and during opcode, address and dummy bits. Any other opcode is ignored and never enables an output.
- R11: Consecutive bytes follow each other with no idle clocks, even when a falling `sck` edge comes only two system clocks after a rising one.
- R12: A write on the load port (`ld_en`, `ld_addr`, `ld_data`) sets the array byte that later reads return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | AW | Array load address |
| ld_data | input | 8 | Array load byte |
| ce_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Primary serial data out |
| so_oe | output | 1 | Drive enable for the primary data pin |
| si_o | output | 1 | Even data bits in two-pin mode |
| si_oe | output | 1 | Drive enable for the data-in pin in two-pin mode |

## Verification
The block registers an output bit one system clock after it samples a falling `sck` level. The bench therefore waits two system clocks after each serial clock transition and reads the pins at the falling edge of `clk`. In mode 0 this sample lands just before the next rising edge, and in mode 3 it lands just after the falling edge of the same bit time. Either way, sample k of a data phase holds bit k. The enables fall in the same system cycle that `ce_n` rises. The bench checks them several cycles later, and it records the enables at every sample of the command, address and dummy phases. Directed reads cover wrap, both identification orders and aborts. Random reads with a fixed seed mix opcode, address, length and clock mode.

// File: rtl/spi_rd_engine.sv
module spi_rd_engine #(
  parameter int          AW      = 8,
  parameter logic [7:0]  ID_MFR  = 8'h8C,
  parameter logic [7:0]  ID_TYPE = 8'h20,
  parameter logic [7:0]  ID_CAP  = 8'h13,
  parameter logic [7:0]  ID_DEV  = 8'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic          ce_n,
  input  logic          sck,
  input  logic          si_i,
  output logic          so_o,
  output logic          so_oe,
  output logic          si_o,
  output logic          si_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {P_CMD, P_ADDR, P_DUMMY, P_DATA, P_SKIP} phase_t;

  logic [7:0]    mem [DEPTH];
  phase_t        phase;
  logic [4:0]    cnt;
  logic [2:0]    pos;
  logic [7:0]    op, sh, src, cur;
  logic [AW-1:0] adr, ptr;
  logic          sck_q, drv, so_q, si_q;

  wire rise   = sck & ~sck_q & ~ce_n;
  wire fall   = ~sck & sck_q & ~ce_n;
  wire dual   = (op == 8'h3B);
  wire [7:0] op_nx = {op[6:0], si_i};
  wire [4:0] dlast = (op == 8'hAB) ? 5'd23 : 5'd7;

  always_comb begin
    case (op)
      8'h9F:   src = (ptr == 0) ? ID_MFR : (ptr == 1) ? ID_TYPE : (ptr == 2) ? ID_CAP : 8'h00;
      8'h90:   src = ptr[0] ? ID_DEV : ID_MFR;
      8'hAB:   src = ID_DEV;
      default: src = mem[ptr];
    endcase
    cur = (pos == 0) ? src : sh;
  end

  always_ff @(posedge clk) if (ld_en) mem[ld_addr] <= ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_CMD; cnt <= '0; pos <= '0; op <= '0; sh <= '0;
      adr <= '0; ptr <= '0; sck_q <= 1'b0; drv <= 1'b0; so_q <= 1'b0; si_q <= 1'b0;
    end else begin
      sck_q <= sck;
      if (ce_n) begin
        phase <= P_CMD; cnt <= '0; pos <= '0; drv <= 1'b0;
      end else if (rise) begin
        case (phase)
          P_CMD: begin
            op  <= op_nx;
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              case (op_nx)
                8'h03, 8'h0B, 8'h3B, 8'h90: phase <= P_ADDR;
                8'h9F:   begin phase <= P_DATA; ptr <= '0; end
                8'hAB:   phase <= P_DUMMY;
                default: phase <= P_SKIP;
              endcase
            end
          end
          P_ADDR: begin
            adr <= {adr[AW-2:0], si_i};
            cnt <= cnt + 5'd1;
            if (cnt == 5'd23) begin
              cnt   <= '0;
              ptr   <= {adr[AW-2:0], si_i};
              phase <= (op == 8'h0B || op == 8'h3B) ? P_DUMMY : P_DATA;
            end
          end
          P_DUMMY: begin
            cnt <= cnt + 5'd1;
            if (cnt == dlast) begin cnt <= '0; phase <= P_DATA; end
          end
          default: ;
        endcase
      end else if (fall && phase == P_DATA) begin
        drv  <= 1'b1;
        so_q <= cur[7];
        si_q <= cur[6];
        sh   <= dual ? {cur[5:0], 2'b00} : {cur[6:0], 1'b0};
        pos  <= (pos == (dual ? 3'd3 : 3'd7)) ? 3'd0 : pos + 3'd1;
        if (pos == 0 && !(op == 8'h9F && ptr == 3)) ptr <= ptr + 1'b1;
      end
    end
  end

  assign so_o  = so_q;
  assign si_o  = si_q;
  assign so_oe = drv & ~ce_n;
  assign si_oe = drv & ~ce_n & dual;

  a_r1_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(so_q));
  a_r10_quiet_outside_data: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> phase == P_DATA);
  a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |=> (phase == P_CMD && cnt == 0 && !so_oe && !si_oe));
  a_r5_ptr_holds_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !fall) |=> $stable(ptr));
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < 5'd24);
endmodule

// File: tb/spi_rd_engine_bench.sv
module spi_rd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic ce_n = 1'b1, sck = 1'b0, si_d = 1'b0;
  logic so_o, so_oe, si_o, si_oe;

  logic [7:0] model [1<<AW];
  int checks = 0, errors = 0;
  bit mode3 = 1'b0;
  bit any_oe;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rd_engine #(.AW(AW)) u_spi_rd_engine (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .ce_n(ce_n), .sck(sck), .si_i(si_d),
    .so_o(so_o), .so_oe(so_oe), .si_o(si_o), .si_oe(si_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk); ld_en = 1'b0;
    model[a] = d;
  endtask

  task automatic tick(input logic d, output logic so_s, output logic si_s);
    if (mode3) begin
      sck = 1'b0; si_d = d;
      repeat (HALF) @(negedge clk);
      so_s = so_o; si_s = si_o; any_oe |= (so_oe | si_oe);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end else begin
      si_d = d;
      repeat (HALF) @(negedge clk);
      so_s = so_o; si_s = si_o; any_oe |= (so_oe | si_oe);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic a, c;
    for (int i = 7; i >= 0; i--) tick(b[i], a, c);
  endtask

  task automatic recv_byte(input bit dual, output logic [7:0] b);
    logic a, c;
    b = '0;
    if (dual) for (int i = 0; i < 4; i++) begin tick(1'b0, a, c); b = {b[5:0], a, c}; end
    else      for (int i = 0; i < 8; i++) begin tick(1'b0, a, c); b = {b[6:0], a}; end
  endtask

  task automatic begin_cmd();
    @(negedge clk); sck = mode3; 
    repeat (2) @(negedge clk); ce_n = 1'b0;
    repeat (2) @(negedge clk);
    any_oe = 1'b0;
  endtask

  task automatic end_cmd();
    @(negedge clk); ce_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 enables released after ce_n high", {so_oe, si_oe}, 2'b00);
  endtask

  function automatic logic [7:0] expect_byte(input logic [7:0] op, input logic [23:0] a, input int k);
    case (op)
      8'h9F:   return (k == 0) ? 8'h8C : (k == 1) ? 8'h20 : (k == 2) ? 8'h13 : 8'h00;
      8'h90:   return ((a[0] ^ k[0]) != 0) ? 8'h12 : 8'h8C;
      8'hAB:   return 8'h12;
      default: return model[(a[AW-1:0] + k) % (1 << AW)];
    endcase
  endfunction

  task automatic do_read(input string req, input logic [7:0] op, input logic [23:0] a, input int n);
    logic [7:0] b;
    bit dual = (op == 8'h3B);
    begin_cmd();
    send_byte(op);
    if (op != 8'h9F) begin
      send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    end
    if (op == 8'h0B || op == 8'h3B) send_byte(8'hA5);
    chk({req, " R10 quiet before data"}, any_oe, 1'b0);
    for (int k = 0; k < n; k++) begin
      recv_byte(dual, b);
      chk({req, " data byte"}, b, expect_byte(op, a, k));
    end
    if (dual) chk("R4 si driven in dual data", si_oe, 1'b1);
    end_cmd();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic a, c;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 reset enables", {so_oe, si_oe}, 2'b00);
    rst_n = 1'b1;
    for (int i = 0; i < (1 << AW); i++) load(i[AW-1:0], 8'($urandom));

    do_read("R2 R12 plain read", 8'h03, 24'h000010, 4);
    do_read("R3 fast read", 8'h0B, 24'h000080, 4);
    do_read("R4 dual read", 8'h3B, 24'h000033, 5);
    do_read("R5 wrap and upper bits ignored", 8'h03, 24'h1234FE, 4);
    do_read("R5 dual wrap", 8'h3B, 24'h0000FF, 3);
    do_read("R6 jedec id", 8'h9F, 24'h0, 5);
    do_read("R7 id even start", 8'h90, 24'h000000, 4);
    do_read("R7 id odd start", 8'h90, 24'h000001, 3);
    begin_cmd();
    send_byte(8'hAB); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    chk("R8 R10 quiet during dummies", any_oe, 1'b0);
    for (int k = 0; k < 3; k++) begin recv_byte(1'b0, b); chk("R8 signature", b, 8'h12); end
    end_cmd();

    begin_cmd();
    send_byte(8'h03); send_byte(8'h00);
    for (int i = 0; i < 4; i++) tick(1'b1, a, c);
    end_cmd();
    do_read("R9 fresh command after abort", 8'h9F, 24'h0, 1);

    begin_cmd();
    send_byte(8'h5A);
    for (int i = 0; i < 16; i++) tick(1'b0, a, c);
    chk("R10 unknown opcode stays quiet", any_oe, 1'b0);
    end_cmd();

    load(8'h40, 8'h3C);
    do_read("R12 reloaded byte", 8'h03, 24'h000040, 1);

    mode3 = 1'b1;
    do_read("R1 mode3 plain", 8'h03, 24'h000020, 3);
    do_read("R1 mode3 dual", 8'h3B, 24'h0000FE, 3);
    mode3 = 1'b0;

    for (int it = 0; it < 20; it++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 2);
      op = (sel == 0) ? 8'h03 : (sel == 1) ? 8'h0B : 8'h3B;
      mode3 = $urandom_range(0, 1);
      do_read("R11 R1 random gapless", op, 24'($urandom), $urandom_range(1, 6));
    end
    mode3 = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule